// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block steps an external converter through a programmed list of 4-bit channel-select entries. A start trigger opens an acquisition window of programmable width. The block then issues a conversion strobe, waits for the converter's done handshake, and writes each returned sample into a bank of result registers. The analog sample/hold stage and the converter are outside the block. They are seen only through the select, window, start, done and data signals.

The block has two sequencer contexts. Each context has its own trigger, its own entry count and its own pointer pair, and the two share one conversion engine. In sequential mode, each list entry names one of 16 inputs and yields one result. In simultaneous mode, only the low three bits of an entry are used. They give one offset that selects an A input and a B input, both held at the same instant. The A input is converted first and the B input second. Their results land in two consecutive registers.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every result register reads zero and `sample_o`, `conv_start_o` and `eos_o` are low. Context 0 reads its first entry at list index 0 and writes its first result at index 0. Context 1 reads its first entry at list index 8 and writes its first result at index 8.
- R2: Each entry starts with `sample_o` high for exactly `acq_ps_i`+1 cycles. A one-cycle `conv_start_o` pulse follows the window, and the two are never high together.
- R3: In sequential mode (`simul_mode_i`=0), all 4 bits of the entry drive `sh_sel_o` and `conv_ch_o`. One conversion is made per entry, its result is stored at the result pointer, and the pointer advances by one.
- R4: In simultaneous mode, bit 3 of the entry is ignored and `sh_sel_o` = {0, entry[2:0]}. The A conversion (`conv_ch_o` = {0, entry[2:0]}) comes first. The B conversion (`conv_ch_o` = {1, entry[2:0]}) comes second, with no new acquisition window between them.
- R5: In simultaneous mode, the A result is stored at the result pointer and the B result at the pointer plus one. The pointer then advances by two.
- R6: One trigger processes (max count + 1) entries. `eos_o[k]` then pulses for one cycle, in the first cycle in which the last result is visible, and the context goes idle.
- R7: If no sequencer reset is applied, the channel and result pointers carry over from the end of one sequence to the start of the next.
- R8: A pulse on `seq_rst_i[k]` returns the channel and result pointers of context k to its start offsets.
- R9: A trigger that arrives while its context is busy is held pending, and a new sequence starts on its own once the current one ends. Several triggers during one sequence produce only one extra sequence.
- R10: When both contexts are active, context 0 is served first at every entry boundary, and both sequences complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| simul_mode_i | input | 1 | 1 = simultaneous A/B mode, 0 = sequential mode |
| acq_ps_i | input | PS_W | Acquisition prescale; window is value+1 cycles |
| chan_list_i | input | LIST_DEPTH*4 | Channel list, entry i at bits [4i+3:4i] |
| max_conv0_i | input | CNT_W | Entries minus one per sequence, context 0 |
| max_conv1_i | input | CNT_W | Entries minus one per sequence, context 1 |
| trig_i | input | 2 | Start trigger per context |
| seq_rst_i | input | 2 | Synchronous pointer reset per context |
| sample_o | output | 1 | Acquisition window active |
| sh_sel_o | output | 4 | Sample/hold input select during the window |
| conv_start_o | output | 1 | One-cycle conversion start strobe |
| conv_ch_o | output | 4 | Input being converted |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | RES_W | Converter result |
| results_o | output | RES_DEPTH*RES_W | Result bank, register i at bits [i*RES_W +: RES_W] |
| eos_o | output | 2 | End-of-sequence pulse per context |

## Verification
The bench uses the default parameters: a 16-entry list, 16 twelve-bit result registers, a 4-bit prescale and a 3-bit entry count. With these values, window widths of 1 and 6 cycles, sequences of one to three entries, and both context start offsets (index 8 of the list and of the bank) are all reachable. The converter model returns a value that encodes the converted input. This lets the bench check both the order of A and B conversions and the register each result lands in. It also uses this to check pending triggers and context priority across shared entry boundaries.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W    = 4;
    localparam int NUM_CTX = 2;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_ACQ,
        ENG_START,
        ENG_WAIT,
        ENG_UPD
    } eng_state_e;

endpackage

// File: rtl/adc_seq_acq_timer.sv
module adc_seq_acq_timer #(
    parameter int PS_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            expired_o
);

    logic [PS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = ps_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - PS_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_result_bank.sv
module adc_seq_result_bank #(
    parameter int DEPTH = 16,
    parameter int W     = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [W-1:0]       data_i,
    output logic [DEPTH*W-1:0] flat_o
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        logic [W-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (we_i && addr_i == AW'(i)) r_d = data_i;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) r_q <= '0;
            else         r_q <= r_d;
        end

        assign flat_o[i*W +: W] = r_q;
    end

endmodule

// File: rtl/adc_seq_ctx.sv
module adc_seq_ctx #(
    parameter int LP_W      = 4,
    parameter int RP_W      = 4,
    parameter int CNT_W     = 3,
    parameter int LIST_BASE = 0,
    parameter int RES_BASE  = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic             done_i,
    input  logic             dual_i,
    output logic             run_o,
    output logic [LP_W-1:0]  chan_ptr_o,
    output logic [RP_W-1:0]  res_ptr_o,
    output logic             eos_o
);

    typedef struct packed {
        logic             run;
        logic             pend;
        logic [LP_W-1:0]  cp;
        logic [RP_W-1:0]  rp;
        logic [CNT_W-1:0] cnt;
        logic             eos;
    } ctx_t;

    ctx_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.eos = 1'b0;

        if (done_i && st_q.run) begin
            st_d.cp = st_q.cp + LP_W'(1);
            st_d.rp = st_q.rp + (dual_i ? RP_W'(2) : RP_W'(1));
            if (st_q.cnt == max_i) begin
                st_d.eos = 1'b1;
                st_d.cnt = '0;
                if (st_q.pend) st_d.pend = 1'b0;
                else           st_d.run  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end

        if (trig_i) begin
            if (st_d.run) begin
                st_d.pend = 1'b1;
            end else begin
                st_d.run = 1'b1;
                st_d.cnt = '0;
            end
        end

        if (clr_i) begin
            st_d.run  = 1'b0;
            st_d.pend = 1'b0;
            st_d.cp   = LP_W'(LIST_BASE);
            st_d.rp   = RP_W'(RES_BASE);
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.cp   <= LP_W'(LIST_BASE);
            st_q.rp   <= RP_W'(RES_BASE);
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o      = st_q.run;
    assign chan_ptr_o = st_q.cp;
    assign res_ptr_o  = st_q.rp;
    assign eos_o      = st_q.eos;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int LIST_DEPTH     = 16,
    parameter int RES_DEPTH      = 16,
    parameter int RES_W          = 12,
    parameter int PS_W           = 4,
    parameter int CNT_W          = 3,
    parameter int CTX1_LIST_BASE = 8,
    parameter int CTX1_RES_BASE  = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       simul_mode_i,
    input  logic [PS_W-1:0]            acq_ps_i,
    input  logic [LIST_DEPTH*CH_W-1:0] chan_list_i,
    input  logic [CNT_W-1:0]           max_conv0_i,
    input  logic [CNT_W-1:0]           max_conv1_i,
    input  logic [NUM_CTX-1:0]         trig_i,
    input  logic [NUM_CTX-1:0]         seq_rst_i,
    output logic                       sample_o,
    output logic [CH_W-1:0]            sh_sel_o,
    output logic                       conv_start_o,
    output logic [CH_W-1:0]            conv_ch_o,
    input  logic                       conv_done_i,
    input  logic [RES_W-1:0]           conv_data_i,
    output logic [RES_DEPTH*RES_W-1:0] results_o,
    output logic [NUM_CTX-1:0]         eos_o
);

    localparam int LP_W = $clog2(LIST_DEPTH);
    localparam int RP_W = $clog2(RES_DEPTH);

    typedef struct packed {
        eng_state_e       state;
        logic             owner;
        logic [CH_W-1:0]  entry;
        logic [RP_W-1:0]  rp;
        logic             half;
        logic [RES_W-1:0] data;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [CH_W-1:0]  list_a   [LIST_DEPTH];
    logic [LP_W-1:0]  cp_a     [NUM_CTX];
    logic [RP_W-1:0]  rp_a     [NUM_CTX];
    logic [CNT_W-1:0] max_a    [NUM_CTX];
    logic [NUM_CTX-1:0] run_w;
    logic [NUM_CTX-1:0] done_w;
    logic             tmr_load;
    logic             tmr_exp;
    logic             bank_we;

    for (genvar i = 0; i < LIST_DEPTH; i++) begin : g_list
        assign list_a[i] = chan_list_i[i*CH_W +: CH_W];
    end

    assign max_a[0] = max_conv0_i;
    assign max_a[1] = max_conv1_i;

    for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
        adc_seq_ctx #(
            .LP_W      (LP_W),
            .RP_W      (RP_W),
            .CNT_W     (CNT_W),
            .LIST_BASE ((k == 0) ? 0 : CTX1_LIST_BASE),
            .RES_BASE  ((k == 0) ? 0 : CTX1_RES_BASE)
        ) i_ctx (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .trig_i     (trig_i[k]),
            .clr_i      (seq_rst_i[k]),
            .max_i      (max_a[k]),
            .done_i     (done_w[k]),
            .dual_i     (simul_mode_i),
            .run_o      (run_w[k]),
            .chan_ptr_o (cp_a[k]),
            .res_ptr_o  (rp_a[k]),
            .eos_o      (eos_o[k])
        );
    end

    adc_seq_acq_timer #(.PS_W(PS_W)) i_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .ps_i      (acq_ps_i),
        .expired_o (tmr_exp)
    );

    always_comb begin
        eng_d    = eng_q;
        tmr_load = 1'b0;
        bank_we  = 1'b0;
        done_w   = '0;

        unique case (eng_q.state)
            ENG_IDLE: begin
                if (run_w != '0) begin
                    eng_d.owner = run_w[0] ? 1'b0 : 1'b1;
                    eng_d.entry = list_a[cp_a[eng_d.owner]];
                    eng_d.rp    = rp_a[eng_d.owner];
                    eng_d.half  = 1'b0;
                    eng_d.state = ENG_ACQ;
                    tmr_load    = 1'b1;
                end
            end
            ENG_ACQ: begin
                if (tmr_exp) eng_d.state = ENG_START;
            end
            ENG_START: begin
                eng_d.state = ENG_WAIT;
            end
            ENG_WAIT: begin
                if (conv_done_i) begin
                    eng_d.data  = conv_data_i;
                    eng_d.state = ENG_UPD;
                end
            end
            ENG_UPD: begin
                bank_we = 1'b1;
                if (simul_mode_i && !eng_q.half) begin
                    eng_d.half  = 1'b1;
                    eng_d.state = ENG_START;
                end else begin
                    done_w[eng_q.owner] = 1'b1;
                    eng_d.state         = ENG_IDLE;
                end
            end
            default: eng_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q       <= '0;
            eng_q.state <= ENG_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    adc_seq_result_bank #(.DEPTH(RES_DEPTH), .W(RES_W)) i_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (bank_we),
        .addr_i (eng_q.rp + RP_W'(eng_q.half)),
        .data_i (eng_q.data),
        .flat_o (results_o)
    );

    assign sample_o     = (eng_q.state == ENG_ACQ);
    assign conv_start_o = (eng_q.state == ENG_START);
    assign sh_sel_o     = simul_mode_i ? {1'b0, eng_q.entry[CH_W-2:0]} : eng_q.entry;
    assign conv_ch_o    = simul_mode_i ? {eng_q.half, eng_q.entry[CH_W-2:0]} : eng_q.entry;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int PS_W = 4
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       simul_mode_i,
    input logic       sample_o,
    input logic [3:0] sh_sel_o,
    input logic       conv_start_o,
    input logic [3:0] conv_ch_o,
    input logic [1:0] eos_o
);

    localparam int CW = PS_W + 2;

    logic [CW-1:0] win_q;
    logic [3:0]    last_ch_q;
    logic          last_vld_q;
    logic          saw_acq_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_q      <= '0;
            last_ch_q  <= '0;
            last_vld_q <= 1'b0;
            saw_acq_q  <= 1'b0;
        end else begin
            win_q <= sample_o ? win_q + CW'(1) : '0;
            if (conv_start_o) begin
                last_ch_q  <= conv_ch_o;
                last_vld_q <= 1'b1;
                saw_acq_q  <= 1'b0;
            end else if (sample_o) begin
                saw_acq_q  <= 1'b1;
            end
        end
    end

    assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conv_start_o |=> !conv_start_o);

    assert_no_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_o && conv_start_o));

    assert_acq_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_q <= CW'(1 << PS_W));

    assert_eos0_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eos_o[0] |=> !eos_o[0]);

    assert_eos1_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eos_o[1] |=> !eos_o[1]);

    assert_simul_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o && simul_mode_i) |-> !sh_sel_o[3]);

    assert_b_after_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (simul_mode_i && conv_start_o && conv_ch_o[3])
            |-> (last_vld_q && last_ch_q == {1'b0, conv_ch_o[2:0]} && !saw_acq_q));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.PS_W(PS_W)) i_adc_seq_ctrl_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .simul_mode_i (simul_mode_i),
    .sample_o     (sample_o),
    .sh_sel_o     (sh_sel_o),
    .conv_start_o (conv_start_o),
    .conv_ch_o    (conv_ch_o),
    .eos_o        (eos_o)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    localparam int LD = 16;
    localparam int RD = 16;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          simul = 1'b0;
    logic [3:0]    acq_ps = '0;
    logic [LD*4-1:0] clist = '0;
    logic [2:0]    max0 = '0;
    logic [2:0]    max1 = '0;
    logic [1:0]    trig = '0;
    logic [1:0]    srst = '0;
    logic          sample;
    logic [3:0]    sh_sel;
    logic          cstart;
    logic [3:0]    cch;
    logic          cdone = 1'b0;
    logic [RW-1:0] cdata = '0;
    logic [RD*RW-1:0] results;
    logic [1:0]    eos;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    int conv_cnt = 0;
    int samp_cyc = 0;
    int acq_rise = 0;
    int eos_cnt0 = 0;
    int eos_cnt1 = 0;
    logic [3:0] conv_log [64];
    logic [3:0] last_sh = '0;
    logic samp_prev = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .simul_mode_i (simul),
        .acq_ps_i     (acq_ps),
        .chan_list_i  (clist),
        .max_conv0_i  (max0),
        .max_conv1_i  (max1),
        .trig_i       (trig),
        .seq_rst_i    (srst),
        .sample_o     (sample),
        .sh_sel_o     (sh_sel),
        .conv_start_o (cstart),
        .conv_ch_o    (cch),
        .conv_done_i  (cdone),
        .conv_data_i  (cdata),
        .results_o    (results),
        .eos_o        (eos)
    );

    always @(negedge clk) begin
        if (cstart) begin
            conv_log[conv_cnt % 64] <= cch;
            conv_cnt <= conv_cnt + 1;
        end
        if (sample) begin
            samp_cyc <= samp_cyc + 1;
            last_sh  <= sh_sel;
        end
        if (sample && !samp_prev) acq_rise <= acq_rise + 1;
        samp_prev <= sample;
        if (eos[0]) eos_cnt0 <= eos_cnt0 + 1;
        if (eos[1]) eos_cnt1 <= eos_cnt1 + 1;
    end

    initial begin
        forever begin
            @(negedge clk);
            if (cstart) begin
                logic [3:0] ch;
                ch = cch;
                repeat (2) @(negedge clk);
                cdone = 1'b1;
                cdata = 12'h500 | RW'(ch);
                @(negedge clk);
                cdone = 1'b0;
            end
        end
    end

    function automatic logic [RW-1:0] res(input int i);
        return results[i*RW +: RW];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    task automatic set_entry(input int idx, input logic [3:0] v);
        clist[idx*4 +: 4] = v;
    endtask

    task automatic pulse_trig(input logic [1:0] m);
        @(negedge clk); trig = m;
        @(negedge clk); trig = '0;
    endtask

    task automatic pulse_rst(input logic [1:0] m);
        @(negedge clk); srst = m;
        @(negedge clk); srst = '0;
    endtask

    task automatic wait_eos(input int k);
        int n;
        n = 0;
        @(negedge clk);
        while (!eos[k] && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < RD; i++) check("R1 result zero after reset", 32'(res(i)), 32'h0);
        check("R1 sample idle", 32'(sample), 32'h0);
        check("R1 conv_start idle", 32'(cstart), 32'h0);
        check("R1 eos idle", 32'(eos), 32'h0);
    endtask

    task automatic t_acq_width(input logic [3:0] ps);
        int s0;
        pulse_rst(2'b01);
        simul = 1'b0; acq_ps = ps; max0 = 3'd0;
        set_entry(0, 4'h2);
        s0 = samp_cyc;
        pulse_trig(2'b01);
        wait_eos(0);
        @(negedge clk);
        check("R2 window length", 32'(samp_cyc - s0), 32'(ps) + 1);
        check("R2 result of window test", 32'(res(0)), 32'h502);
    endtask

    task automatic t_sequential();
        int c0, e0;
        pulse_rst(2'b01);
        simul = 1'b0; acq_ps = 4'd1; max0 = 3'd2;
        set_entry(0, 4'hB); set_entry(1, 4'h3); set_entry(2, 4'hE);
        c0 = conv_cnt; e0 = eos_cnt0;
        pulse_trig(2'b01);
        wait_eos(0);
        check("R6 last result visible with eos", 32'(res(2)), 32'h50E);
        check("R3 entry 0 result", 32'(res(0)), 32'h50B);
        check("R3 entry 1 result", 32'(res(1)), 32'h503);
        check("R3 register after sequence untouched", 32'(res(3)), 32'h0);
        @(negedge clk);
        check("R6 eos lasts one cycle", 32'(eos[0]), 32'h0);
        repeat (20) @(negedge clk);
        check("R3 one conversion per entry", 32'(conv_cnt - c0), 32'd3);
        check("R6 one eos per sequence", 32'(eos_cnt0 - e0), 32'd1);
        check("R6 idle after sequence", 32'(sample), 32'h0);
    endtask

    task automatic t_persist();
        max0 = 3'd0;
        set_entry(3, 4'h7);
        pulse_trig(2'b01);
        wait_eos(0);
        check("R7 pointers carried over", 32'(res(3)), 32'h507);
    endtask

    task automatic t_seqrst();
        pulse_rst(2'b01);
        set_entry(0, 4'hD);
        max0 = 3'd0;
        pulse_trig(2'b01);
        wait_eos(0);
        check("R8 pointers back at start", 32'(res(0)), 32'h50D);
        check("R8 old slot untouched", 32'(res(4)), 32'h0);
    endtask

    task automatic t_simul();
        int c0, a0;
        pulse_rst(2'b01);
        simul = 1'b1; acq_ps = 4'd2; max0 = 3'd1;
        set_entry(0, 4'b0110); set_entry(1, 4'b1001);
        c0 = conv_cnt; a0 = acq_rise;
        pulse_trig(2'b01);
        wait_eos(0);
        check("R5 A result of 0110", 32'(res(0)), 32'h506);
        check("R5 B result of 0110", 32'(res(1)), 32'h50E);
        check("R5 A result of 1001", 32'(res(2)), 32'h501);
        check("R5 B result of 1001", 32'(res(3)), 32'h509);
        check("R4 conversions made", 32'(conv_cnt - c0), 32'd4);
        check("R4 first A", 32'(conv_log[c0 % 64]), 32'h6);
        check("R4 then B", 32'(conv_log[(c0 + 1) % 64]), 32'hE);
        check("R4 one window per entry", 32'(acq_rise - a0), 32'd2);
    endtask

    task automatic t_topbit();
        pulse_rst(2'b01);
        simul = 1'b1; max0 = 3'd0;
        set_entry(0, 4'b1110);
        pulse_trig(2'b01);
        wait_eos(0);
        check("R4 sh_sel top bit dropped", 32'(last_sh), 32'h6);
        check("R4 A result with top bit set", 32'(res(0)), 32'h506);
        check("R4 B result with top bit set", 32'(res(1)), 32'h50E);
        simul = 1'b0;
    endtask

    task automatic t_ctx1();
        simul = 1'b0; max1 = 3'd0;
        set_entry(8, 4'h4);
        pulse_trig(2'b10);
        wait_eos(1);
        check("R1 context 1 start offsets", 32'(res(8)), 32'h504);
    endtask

    task automatic t_pending();
        int c0, e0;
        pulse_rst(2'b01);
        simul = 1'b0; acq_ps = 4'd3; max0 = 3'd0;
        set_entry(0, 4'h2); set_entry(1, 4'h5);
        c0 = conv_cnt; e0 = eos_cnt0;
        pulse_trig(2'b01);
        while (!sample) @(negedge clk);
        pulse_trig(2'b01);
        pulse_trig(2'b01);
        wait_eos(0);
        wait_eos(0);
        repeat (40) @(negedge clk);
        check("R9 first sequence result", 32'(res(0)), 32'h502);
        check("R9 pending sequence result", 32'(res(1)), 32'h505);
        check("R9 triggers collapse to one", 32'(conv_cnt - c0), 32'd2);
        check("R9 two eos pulses", 32'(eos_cnt0 - e0), 32'd2);
    endtask

    task automatic t_priority();
        int c0, e0, e1;
        pulse_rst(2'b11);
        simul = 1'b0; acq_ps = 4'd0; max0 = 3'd1; max1 = 3'd1;
        set_entry(0, 4'h1); set_entry(1, 4'h2);
        set_entry(8, 4'h8); set_entry(9, 4'h9);
        c0 = conv_cnt; e0 = eos_cnt0; e1 = eos_cnt1;
        pulse_trig(2'b11);
        repeat (100) @(negedge clk);
        check("R10 first served", 32'(conv_log[c0 % 64]), 32'h1);
        check("R10 second served", 32'(conv_log[(c0 + 1) % 64]), 32'h2);
        check("R10 third served", 32'(conv_log[(c0 + 2) % 64]), 32'h8);
        check("R10 fourth served", 32'(conv_log[(c0 + 3) % 64]), 32'h9);
        check("R10 context 1 result", 32'(res(9)), 32'h509);
        check("R10 both contexts finish", 32'((eos_cnt0 - e0) + (eos_cnt1 - e1)), 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ctx1();
        t_acq_width(4'd0);
        t_acq_width(4'd5);
        t_sequential();
        t_persist();
        t_seqrst();
        t_simul();
        t_topbit();
        t_pending();
        t_priority();
        summary();
        $finish;
    end

endmodule